// File: doc/BRIEF.md
# TLB Invalidate Snoop Controller

This block owns the valid bits of a two-way, set-associative address translation buffer and decides when those bits are cleared. A clear always removes every way of one congruence class. The class is chosen by six bits of a 32-bit effective address. A clear can come from two places. One is the local core, whose request is also driven onto the shared system bus as an invalidate operation so that other processors drop the same class. The other is an invalidate seen on that bus from another processor. A snooped invalidate is taken only when the bus retry line is quiet and the local unit has no invalidate of its own in flight. If a multi-word load/store or string instruction is running, the clear is held until that instruction ends.

The block also drives a translation-sync bus operation on request. That opcode is distinct from the memory-sync opcode. One such operation placed after any number of invalidates tells the system that all of them are complete. An invalidate-all request is not supported: it raises a one-cycle illegal-instruction pulse. To clear the whole buffer, software issues one invalidate per class index (64 in all), followed by a single sync.

A fill port sets valid bits and a probe port reads the valid bits of one set. These two ports stand in for the lookup and reload paths.

Top module: `tlbi_snoop_ctrl`

## Requirements
- R1: The class index is `loc_ea_i[17:12]` (effective-address bits 14 to 19 counted from the most significant bit of a 32-bit address). An invalidate clears both ways of that set and leaves every other set and every other address bit without effect.
- R2: A local invalidate taken at a clock edge drives `bus_op_o` = 2'b01 with `bus_idx_o` = index for exactly the following cycle. The indexed set is cleared at the next edge.
- R3: `loc_busy_o` is high while a snooped invalidate is pending, while a snooped invalidate is being taken in the same cycle, or while a local invalidate is in flight. A local request made while busy is dropped: no bus operation and no clear.
- R4: A snooped operation is ignored when `snoop_retry_i` is high or when its opcode is not 2'b01.
- R5: A snooped invalidate that arrives while a local invalidate is in flight, or while another snooped invalidate is pending, is not taken. In that cycle `snp_retry_o` is high.
- R6: A snooped invalidate taken while `multi_busy_i` is low clears its set at the same edge.
- R7: A snooped invalidate taken while `multi_busy_i` is high stays pending and clears its set at the first edge at which `multi_busy_i` is low. Local requests are held off until then.
- R8: A sync request drives `bus_op_o` = 2'b10 for one cycle. If it coincides with a local invalidate being taken, the invalidate goes out first and the sync goes out in the following cycle. The block never drives 2'b11 (memory-sync).
- R9: An invalidate-all request raises `illegal_o` for exactly the next cycle. It causes no bus operation and no change to the array.
- R10: After reset every valid bit is 0, `bus_op_o` = 2'b00, and `loc_busy_o`, `snp_retry_o` and `illegal_o` are 0.
- R11: A fill sets the valid bit of the selected way. A clear of the same set at the same edge takes priority over the fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| loc_inv_req_i | input | 1 | Local invalidate-entry request |
| loc_ea_i | input | 32 | Effective address of local invalidate |
| loc_busy_o | output | 1 | Local request would be dropped this cycle |
| loc_sync_req_i | input | 1 | Local translation-sync request |
| inv_all_req_i | input | 1 | Unsupported invalidate-all request |
| illegal_o | output | 1 | Illegal-instruction exception pulse |
| bus_op_o | output | 2 | Bus opcode: 00 idle, 01 invalidate, 10 translation-sync, 11 memory-sync |
| bus_idx_o | output | 6 | Class index sent with invalidate |
| snoop_op_i | input | 2 | Snooped bus opcode |
| snoop_idx_i | input | 6 | Snooped class index |
| snoop_retry_i | input | 1 | Combined address-retry from the bus |
| snp_retry_o | output | 1 | This unit cannot take the snooped invalidate |
| multi_busy_i | input | 1 | Multi-word or string instruction executing |
| fill_en_i | input | 1 | Set one valid bit |
| fill_idx_i | input | 6 | Fill set |
| fill_way_i | input | 1 | Fill way |
| probe_idx_i | input | 6 | Set to read |
| probe_vld_o | output | 2 | Valid bits of probed set |

## Verification
The assertions take for granted that the snoop inputs never carry this unit's own broadcast, that each snooped opcode is present for one cycle, and that `multi_busy_i` is a level that eventually drops. The assertion that only one clear source acts per edge depends on these points. The bench drives every input on the falling edge, presents each snooped operation for a single cycle, and always releases `multi_busy_i` within a few cycles. The bench also never presents its own broadcasts on the snoop inputs.

// File: rtl/tlbi_pkg.sv
// Shared constants and bus opcode encoding for the TLB invalidate controller.
// Assumes a 32-bit effective address with the class index at bits [17:12].
package tlbi_pkg;
    localparam int EA_W    = 32;
    localparam int IDX_W   = 6;
    localparam int IDX_LSB = 12;
    localparam int WAYS    = 2;

    typedef enum logic [1:0] {
        BOP_IDLE  = 2'b00,
        BOP_INVAL = 2'b01,
        BOP_XSYNC = 2'b10,
        BOP_MSYNC = 2'b11
    } bus_op_e;
endpackage

// File: rtl/tlbi_valid_array.sv
// Valid-bit storage of the translation buffer: SETS x WAYS bits.
// Two clear ports (local, snoop) each wipe all ways of one set; a fill
// port sets one bit. A clear beats a fill on the same set.
// Assumes the two clear ports are never active together.
module tlbi_valid_array #(
    parameter int IDX_W = 6,
    parameter int WAYS  = 2,
    localparam int SETS = 1 << IDX_W,
    localparam int WW   = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_a_en,
    input  logic [IDX_W-1:0] clr_a_idx,
    input  logic             clr_b_en,
    input  logic [IDX_W-1:0] clr_b_idx,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [WW-1:0]    fill_way,
    input  logic [IDX_W-1:0] probe_idx,
    output logic [WAYS-1:0]  probe_vld
);
    logic [WAYS-1:0] vld_q [SETS];

    for (genvar s = 0; s < SETS; s++) begin : g_set
        logic hit_clr;
        assign hit_clr = (clr_a_en && clr_a_idx == IDX_W'(s)) ||
                         (clr_b_en && clr_b_idx == IDX_W'(s));
        // Per-set update: clear wins over fill.
        always_ff @(posedge clk) begin
            if (!rst_n)
                vld_q[s] <= '0;
            else if (hit_clr)
                vld_q[s] <= '0;
            else if (fill_en && fill_idx == IDX_W'(s))
                vld_q[s][fill_way] <= 1'b1;
        end
    end

    // Read port for the probe.
    assign probe_vld = vld_q[probe_idx];

    // R5
    clr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(clr_a_en && clr_b_en));
    // R1
    clr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_b_en |=> (vld_q[$past(clr_b_idx)] == '0));
endmodule

// File: rtl/tlbi_snoop_gate.sv
// Accept/defer logic for invalidates snooped from the bus.
// Takes a snooped invalidate when retry is quiet, no local invalidate is in
// flight and none is pending; clears at once unless a multi-word
// instruction runs, in which case the index is held until it ends.
// Assumes each snooped opcode is present for one cycle.
module tlbi_snoop_gate
    import tlbi_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       snoop_op_i,
    input  logic [IDX_W-1:0] snoop_idx_i,
    input  logic             snoop_retry_i,
    input  logic             multi_busy_i,
    input  logic             loc_active_i,
    output logic             snp_block_o,
    output logic             snp_retry_o,
    output logic             clr_en_o,
    output logic [IDX_W-1:0] clr_idx_o
);
    logic             pend_q;
    logic [IDX_W-1:0] pend_idx_q;
    logic             snp_inv, snp_take;

    // Decode and acceptance of the snooped operation.
    always_comb begin
        snp_inv     = (snoop_op_i == BOP_INVAL) && !snoop_retry_i;
        snp_take    = snp_inv && !loc_active_i && !pend_q;
        snp_retry_o = snp_inv && (loc_active_i || pend_q);
        snp_block_o = pend_q || snp_take;
        clr_en_o    = !multi_busy_i && (pend_q || snp_take);
        clr_idx_o   = pend_q ? pend_idx_q : snoop_idx_i;
    end

    // Pending register for invalidates held behind a multi-word instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q     <= 1'b0;
            pend_idx_q <= '0;
        end else if (pend_q && !multi_busy_i) begin
            pend_q <= 1'b0;
        end else if (snp_take && multi_busy_i) begin
            pend_q     <= 1'b1;
            pend_idx_q <= snoop_idx_i;
        end
    end

    // R7
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && multi_busy_i) |=> (pend_q && $stable(pend_idx_q)));
    // R4
    retry_ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_retry_i && !pend_q) |=> !pend_q);
endmodule

// File: rtl/tlbi_bus_issue.sv
// Local side: takes local invalidates when not blocked, broadcasts them,
// schedules translation-sync after any same-cycle invalidate, and raises
// the illegal-instruction pulse for invalidate-all.
// Assumes snp_block_i reflects snoop work pending or being taken now.
module tlbi_bus_issue
    import tlbi_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             loc_inv_req_i,
    input  logic [IDX_W-1:0] loc_idx_i,
    input  logic             loc_sync_req_i,
    input  logic             inv_all_req_i,
    input  logic             snp_block_i,
    output logic             loc_busy_o,
    output logic             loc_active_o,
    output logic [IDX_W-1:0] loc_idx_o,
    output logic [1:0]       bus_op_o,
    output logic [IDX_W-1:0] bus_idx_o,
    output logic             illegal_o
);
    bus_op_e          bus_op_q;
    logic [IDX_W-1:0] bus_idx_q;
    logic             active_q, sync_pend_q, illegal_q, loc_take, sync_want;

    // Busy and take decisions for the local request.
    always_comb begin
        loc_busy_o = snp_block_i || active_q;
        loc_take   = loc_inv_req_i && !loc_busy_o;
        sync_want  = loc_sync_req_i || sync_pend_q;
    end

    // Bus driver: invalidate first, then any outstanding sync.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_op_q    <= BOP_IDLE;
            bus_idx_q   <= '0;
            active_q    <= 1'b0;
            sync_pend_q <= 1'b0;
        end else begin
            active_q <= loc_take;
            if (loc_take) begin
                bus_op_q    <= BOP_INVAL;
                bus_idx_q   <= loc_idx_i;
                sync_pend_q <= sync_want;
            end else if (sync_want) begin
                bus_op_q    <= BOP_XSYNC;
                sync_pend_q <= 1'b0;
            end else begin
                bus_op_q <= BOP_IDLE;
            end
        end
    end

    // One-cycle illegal-instruction pulse for invalidate-all.
    always_ff @(posedge clk) begin
        if (!rst_n) illegal_q <= 1'b0;
        else        illegal_q <= inv_all_req_i;
    end

    assign loc_active_o = active_q;
    assign loc_idx_o    = bus_idx_q;
    assign bus_op_o     = bus_op_q;
    assign bus_idx_o    = bus_idx_q;
    assign illegal_o    = illegal_q;

    // R3
    busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_inv_req_i && loc_busy_o) |=> (bus_op_o != 2'b01));
    // R2
    inv_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_op_o == 2'b01) |=> (bus_op_o != 2'b01));
    // R8
    no_msync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_op_o != 2'b11);
    // R9
    illegal_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all_req_i |=> illegal_o);
endmodule

// File: rtl/tlbi_snoop_ctrl.sv
// Top of the TLB invalidate controller: extracts the class index from the
// local effective address, joins local issue, snoop gating and valid array.
// Assumes the snoop inputs never carry this unit's own broadcasts.
module tlbi_snoop_ctrl
    import tlbi_pkg::*;
#(
    parameter int EAW  = EA_W,
    parameter int IW   = IDX_W,
    parameter int ILSB = IDX_LSB
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           loc_inv_req_i,
    input  logic [EAW-1:0] loc_ea_i,
    output logic           loc_busy_o,
    input  logic           loc_sync_req_i,
    input  logic           inv_all_req_i,
    output logic           illegal_o,
    output logic [1:0]     bus_op_o,
    output logic [IW-1:0]  bus_idx_o,
    input  logic [1:0]     snoop_op_i,
    input  logic [IW-1:0]  snoop_idx_i,
    input  logic           snoop_retry_i,
    output logic           snp_retry_o,
    input  logic           multi_busy_i,
    input  logic           fill_en_i,
    input  logic [IW-1:0]  fill_idx_i,
    input  logic           fill_way_i,
    input  logic [IW-1:0]  probe_idx_i,
    output logic [1:0]     probe_vld_o
);
    logic [IW-1:0] loc_idx, loc_clr_idx, snp_clr_idx;
    logic          loc_active, snp_block, snp_clr_en;

    assign loc_idx = loc_ea_i[ILSB +: IW];

    tlbi_bus_issue #(.IDX_W(IW)) u_issue (
        .clk(clk), .rst_n(rst_n),
        .loc_inv_req_i(loc_inv_req_i), .loc_idx_i(loc_idx),
        .loc_sync_req_i(loc_sync_req_i), .inv_all_req_i(inv_all_req_i),
        .snp_block_i(snp_block), .loc_busy_o(loc_busy_o),
        .loc_active_o(loc_active), .loc_idx_o(loc_clr_idx),
        .bus_op_o(bus_op_o), .bus_idx_o(bus_idx_o), .illegal_o(illegal_o)
    );

    tlbi_snoop_gate #(.IDX_W(IW)) u_gate (
        .clk(clk), .rst_n(rst_n),
        .snoop_op_i(snoop_op_i), .snoop_idx_i(snoop_idx_i),
        .snoop_retry_i(snoop_retry_i), .multi_busy_i(multi_busy_i),
        .loc_active_i(loc_active), .snp_block_o(snp_block),
        .snp_retry_o(snp_retry_o), .clr_en_o(snp_clr_en),
        .clr_idx_o(snp_clr_idx)
    );

    tlbi_valid_array #(.IDX_W(IW), .WAYS(WAYS)) u_array (
        .clk(clk), .rst_n(rst_n),
        .clr_a_en(loc_active), .clr_a_idx(loc_clr_idx),
        .clr_b_en(snp_clr_en), .clr_b_idx(snp_clr_idx),
        .fill_en(fill_en_i), .fill_idx(fill_idx_i), .fill_way(fill_way_i),
        .probe_idx(probe_idx_i), .probe_vld(probe_vld_o)
    );

    // R6
    snp_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_op_i == 2'b01 && !snoop_retry_i && !loc_active && !multi_busy_i
         && !snp_retry_o) |=> (u_array.vld_q[$past(snoop_idx_i)] == '0));
endmodule

// File: tb/tlbi_snoop_ctrl_tb.sv
// Directed bench for tlbi_snoop_ctrl: one task per scenario, shadow model
// of the valid bits kept from the requirements.
module tlbi_snoop_ctrl_tb;
    logic        clk = 0, rst_n = 0;
    logic        loc_inv_req_i = 0, loc_sync_req_i = 0, inv_all_req_i = 0;
    logic [31:0] loc_ea_i = '0;
    logic        loc_busy_o, illegal_o, snp_retry_o;
    logic [1:0]  bus_op_o, probe_vld_o;
    logic [5:0]  bus_idx_o;
    logic [1:0]  snoop_op_i = 0;
    logic [5:0]  snoop_idx_i = 0, fill_idx_i = 0, probe_idx_i = 0;
    logic        snoop_retry_i = 0, multi_busy_i = 0, fill_en_i = 0, fill_way_i = 0;

    int checks = 0, errors = 0;
    logic [1:0] exp_v [64];

    always #5 clk = ~clk;

    tlbi_snoop_ctrl u_dut (.*);

    task automatic tick; @(posedge clk); @(negedge clk); endtask

    task automatic chk(string req, int act, int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic logic [31:0] ea_of(logic [5:0] idx);
        return (32'hA5A5_A5A5 & ~32'h0003_F000) | (32'(idx) << 12);
    endfunction

    task automatic cmp_array(string req);
        int bad = -1;
        for (int i = 0; i < 64; i++) begin
            probe_idx_i = 6'(i); #1;
            if (probe_vld_o !== exp_v[i] && bad < 0) bad = i;
        end
        if (bad < 0) chk(req, 0, 0);
        else begin probe_idx_i = 6'(bad); #1; chk(req, int'(probe_vld_o), int'(exp_v[bad])); end
    endtask

    task automatic fill_all;
        for (int i = 0; i < 64; i++)
            for (int w = 0; w < 2; w++) begin
                fill_en_i = 1; fill_idx_i = 6'(i); fill_way_i = w[0]; tick;
            end
        fill_en_i = 0;
        for (int i = 0; i < 64; i++) exp_v[i] = 2'b11;
    endtask

    task automatic t_reset;
        for (int i = 0; i < 64; i++) exp_v[i] = 2'b00;
        chk("R10 bus_op", bus_op_o, 0);
        chk("R10 busy", loc_busy_o, 0);
        chk("R10 illegal", illegal_o, 0);
        chk("R10 snp_retry", snp_retry_o, 0);
        cmp_array("R10 array");
    endtask

    task automatic t_local(logic [5:0] idx);
        loc_inv_req_i = 1; loc_ea_i = ea_of(idx); tick;
        loc_inv_req_i = 0;
        chk("R2 bus_op", bus_op_o, 1);
        chk("R2 bus_idx", bus_idx_o, idx);
        chk("R3 busy in flight", loc_busy_o, 1);
        tick;
        chk("R2 one cycle", bus_op_o, 0);
        exp_v[idx] = 0;
        cmp_array("R1 local clear");
    endtask

    task automatic t_snoop_now(logic [5:0] idx);
        snoop_op_i = 2'b01; snoop_idx_i = idx; tick;
        snoop_op_i = 0; exp_v[idx] = 0;
        cmp_array("R6 immediate clear");
    endtask

    task automatic t_snoop_ignored;
        snoop_op_i = 2'b01; snoop_idx_i = 6'd7; snoop_retry_i = 1; tick;
        snoop_retry_i = 0; snoop_op_i = 2'b10; tick;
        snoop_op_i = 2'b11; tick;
        snoop_op_i = 0;
        cmp_array("R4 retried or other opcode ignored");
    endtask

    task automatic t_snoop_vs_local;
        loc_inv_req_i = 1; loc_ea_i = ea_of(6'd20); tick;
        loc_inv_req_i = 0;
        snoop_op_i = 2'b01; snoop_idx_i = 6'd21; #1;
        chk("R5 snp_retry_o", snp_retry_o, 1);
        tick; snoop_op_i = 0;
        exp_v[20] = 0;
        cmp_array("R5 snoop not taken during local");
        tick;
    endtask

    task automatic t_deferred;
        multi_busy_i = 1; snoop_op_i = 2'b01; snoop_idx_i = 6'd30; tick;
        snoop_op_i = 0;
        chk("R7 held while multi", (probe_at(6'd30)), 3);
        chk("R3 busy while pending", loc_busy_o, 1);
        loc_inv_req_i = 1; loc_ea_i = ea_of(6'd31); tick;
        loc_inv_req_i = 0;
        chk("R3 dropped no bus op", bus_op_o, 0);
        snoop_op_i = 2'b01; snoop_idx_i = 6'd32; #1;
        chk("R5 retry while pending", snp_retry_o, 1);
        tick; snoop_op_i = 0; tick;
        chk("R7 still held", probe_at(6'd30), 3);
        multi_busy_i = 0; tick;
        exp_v[30] = 0;
        cmp_array("R7 release clears only pending set");
        chk("R7 busy released", loc_busy_o, 0);
    endtask

    function automatic int probe_at(logic [5:0] idx);
        return int'(u_dut.u_array.vld_q[idx]);
    endfunction

    task automatic t_same_cycle;
        snoop_op_i = 2'b01; snoop_idx_i = 6'd40;
        loc_inv_req_i = 1; loc_ea_i = ea_of(6'd41); #1;
        chk("R3 busy when snoop taken", loc_busy_o, 1);
        tick; snoop_op_i = 0; loc_inv_req_i = 0;
        chk("R3 local dropped", bus_op_o, 0);
        tick; exp_v[40] = 0;
        cmp_array("R3 only snoop set cleared");
    endtask

    task automatic t_sync;
        loc_sync_req_i = 1; tick; loc_sync_req_i = 0;
        chk("R8 sync op", bus_op_o, 2);
        tick; chk("R8 sync one cycle", bus_op_o, 0);
        loc_sync_req_i = 1; loc_inv_req_i = 1; loc_ea_i = ea_of(6'd50); tick;
        loc_sync_req_i = 0; loc_inv_req_i = 0;
        chk("R8 inval first", bus_op_o, 1);
        tick; chk("R8 sync after inval", bus_op_o, 2);
        tick; chk("R8 idle after", bus_op_o, 0);
        exp_v[50] = 0;
    endtask

    task automatic t_inv_all;
        inv_all_req_i = 1; tick; inv_all_req_i = 0;
        chk("R9 illegal pulse", illegal_o, 1);
        chk("R9 no bus op", bus_op_o, 0);
        tick; chk("R9 pulse ends", illegal_o, 0);
        cmp_array("R9 array untouched");
    endtask

    task automatic t_fill_vs_clear;
        exp_v[60] = 2'b01;
        fill_en_i = 1; fill_idx_i = 6'd60; fill_way_i = 1;
        snoop_op_i = 2'b01; snoop_idx_i = 6'd60; tick;
        fill_en_i = 0; snoop_op_i = 0; exp_v[60] = 0;
        cmp_array("R11 clear beats fill");
        fill_en_i = 1; fill_way_i = 1; tick; fill_en_i = 0;
        exp_v[60] = 2'b10;
        cmp_array("R11 fill sets way");
    endtask

    initial begin
        repeat (3) tick;
        rst_n = 1; tick;
        t_reset;
        fill_all;
        t_local(6'd5);
        t_local(6'd63);
        t_snoop_now(6'd0);
        t_snoop_ignored;
        t_snoop_vs_local;
        t_deferred;
        t_same_cycle;
        t_sync;
        t_inv_all;
        t_fill_vs_clear;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule